// File: doc/BRIEF.md
# SPI Receiver Enable Controller

This block owns the receiver-enable control bit of an SPI peripheral and the handshake that turns a software write into a receiver that is actually running. Software writes the bit through a single-cycle write strobe. The block also sees the peripheral's global enable level and a ready level returned by the receive path. That path may run on a slower, unrelated clock, so the ready level is resynchronised inside the block. The block drives the value software reads back, a synchronization-busy flag, a one-cycle flush strobe for the receive buffer and a one-cycle clear for the overflow status.

Turning the receiver off takes effect on the next clock edge. The buffer is emptied, any character that lands in that window is lost, and the overflow flag drops. Turning it on while the peripheral is idle is also immediate. Turning it on while the peripheral is running is deferred: the busy flag rises, the bit reads back 0, and both settle only after the receive path confirms. A write of 0 during that wait cancels the enable. The write is accepted at all times, because this bit has no lock tied to the global enable.

A small receive FIFO with a sticky overflow flag is included so that the flush and the accept gating can be seen at the ports. The FIFO holds completed characters only, and it accepts them only while the receiver reads back as enabled and the peripheral is on.

Top module: `spi_rxen_ctrl`

## Requirements
- R1: After reset, rx_en_req, rxen_rd, sync_busy, flush, ovf_clr, rd_valid and ovf are all 0.
- R2: A write with wr_val=0 is accepted whatever periph_en is. In the next cycle rxen_rd and rx_en_req are 0, and flush is 1 for exactly one cycle.
- R3: One cycle after the flush pulse, rd_valid and ovf are 0. A character completing in the write cycle or in the flush cycle is not kept.
- R4: A write with wr_val=1 while periph_en=0 and the bit is clear gives rxen_rd=1 and sync_busy=0 in the next cycle.
- R5: A write with wr_val=1 while periph_en=1 and the bit is clear gives sync_busy=1, rxen_rd=0 and rx_en_req=1 in the next cycle.
- R6: sync_busy stays 1 until the synchronised rx_rdy equals rx_en_req. After a deferred enable it then drops, and rxen_rd becomes 1. With a receive path that answers within 3 of its own clocks, this happens within 20 bus cycles.
- R7: A write of 0 while an enable is pending makes rxen_rd 0 at once. sync_busy then clears once rx_rdy is seen low again, and rxen_rd stays 0.
- R8: char_done has no effect on rd_valid, rd_data or ovf unless rxen_rd=1 and periph_en=1.
- R9: Accepted characters leave in arrival order. rd_valid=1 exactly when the FIFO holds data, and rd_data shows the oldest entry. pop removes the oldest entry, and pop on an empty FIFO does nothing.
- R10: A character that completes while the FIFO holds DEPTH entries, with no pop in that cycle, is dropped. ovf becomes 1 in the next cycle and stays 1 until a flush.
- R11: ovf_clr pulses in the flush cycle only if ovf was 1 at that time.
- R12: A write with wr_val=1 while rxen_rd is already 1 changes nothing: rxen_rd stays 1 and sync_busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe for the enable bit |
| wr_val | input | 1 | Value written with wr_en |
| periph_en | input | 1 | Global enable level of the peripheral |
| rx_rdy | input | 1 | Ready level from the receive path, asynchronous |
| char_done | input | 1 | A character has completed this cycle |
| char_data | input | CHAR_W | Completed character |
| pop | input | 1 | Remove the oldest FIFO entry |
| rx_en_req | output | 1 | Requested receiver state toward the receive path |
| rxen_rd | output | 1 | Readback value of the enable bit |
| sync_busy | output | 1 | Enable or cancel handshake in flight |
| flush | output | 1 | One-cycle buffer flush strobe |
| ovf_clr | output | 1 | One-cycle clear of the overflow status |
| rd_valid | output | 1 | FIFO holds at least one character |
| rd_data | output | CHAR_W | Oldest FIFO character |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Several rules are checked on every cycle:
- the one-edge effect of each write (off, immediate on, deferred on, repeated on);
- busy holding while the synchronised ready disagrees with the request;
- the FIFO being empty after a flush;
- overflow setting on a dropped character;
- FIFO state holding still when nothing is accepted or popped.

Other behaviour depends on the round trip through the receive clock, so only the bench scenarios show it. This covers the bounded time for busy to clear, the readback turning 1 at that point, the cancel sequence, and whether characters and their order survive random traffic with overflow.

// File: rtl/spi_rxen_pkg.sv
package spi_rxen_pkg;

   // Handshake states of the enable bit
   typedef enum logic [1:0] {
      RXE_OFF    = 2'd0,   // disabled, settled
      RXE_ON     = 2'd1,   // enabled, settled
      RXE_ARM    = 2'd2,   // enable requested, waiting for confirmation
      RXE_CANCEL = 2'd3    // enable withdrawn, waiting for receive path to drop
   } rxe_state_e;

   function automatic logic st_wants(rxe_state_e s);
      return (s == RXE_ON) || (s == RXE_ARM);
   endfunction

   function automatic logic st_busy(rxe_state_e s);
      return (s == RXE_ARM) || (s == RXE_CANCEL);
   endfunction

endpackage

// File: rtl/spi_rxen_sync.sv
module spi_rxen_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_rxen_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_rxen_fsm.sv
module spi_rxen_fsm
   import spi_rxen_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic wr_val,
   input  logic periph_en,
   input  logic rdy_s,
   output logic req,
   output logic rd,
   output logic busy,
   output logic flush
);

   rxe_state_e st, st_nxt;
   logic       flush_q;

   always_comb begin
      st_nxt = st;
      if (wr_en && !wr_val) begin
         st_nxt = st_busy(st) ? RXE_CANCEL : RXE_OFF;
      end else if (wr_en && wr_val) begin
         if (!st_wants(st)) st_nxt = periph_en ? RXE_ARM : RXE_ON;
      end else begin
         unique case (st)
            RXE_ARM:    if (rdy_s)  st_nxt = RXE_ON;
            RXE_CANCEL: if (!rdy_s) st_nxt = RXE_OFF;
            default:    st_nxt = st;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= RXE_OFF;
         flush_q <= 1'b0;
      end else begin
         st      <= st_nxt;
         flush_q <= wr_en && !wr_val;
      end
   end

   assign req   = st_wants(st);
   assign busy  = st_busy(st);
   assign rd    = (st == RXE_ON);
   assign flush = flush_q;

   AST_DIS_NOW: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !wr_val) |=> (!rd && !req && flush)); // R2
   AST_FLUSH_ONE: assert property (@(posedge clk) disable iff (!rst_n) (flush && !$past(wr_en && !wr_val, 1)) |-> 1'b0 || !flush); // R2
   AST_EN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_val && !periph_en && !req) |=> (rd && !busy)); // R4
   AST_EN_DEFER: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_val && periph_en && !req) |=> (busy && !rd && req)); // R5
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (busy && (rdy_s != req) && !(wr_en && wr_val)) |=> busy); // R6
   AST_REWRITE_ONE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_val && rd) |=> (rd && !busy)); // R12

endmodule

// File: rtl/spi_rxen_fifo.sv
module spi_rxen_fifo #(
   parameter int CHAR_W = 9,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push_req,
   input  logic [CHAR_W-1:0] push_data,
   input  logic              pop,
   output logic              rd_valid,
   output logic [CHAR_W-1:0] rd_data,
   output logic              ovf
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("spi_rxen_fifo: DEPTH must be at least 1");
   end
   if (CHAR_W < 1) begin : g_bad_width
      $error("spi_rxen_fifo: CHAR_W must be at least 1");
   end

   logic full, empty, do_pop, do_push;

   assign do_pop  = pop && !empty;
   assign do_push = push_req && !flush && (!full || do_pop);

   if (DEPTH == 1) begin : g_single
      logic              vld;
      logic [CHAR_W-1:0] hold;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       vld <= 1'b0;
         else if (flush)   vld <= 1'b0;
         else if (do_push) vld <= 1'b1;
         else if (do_pop)  vld <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (do_push) hold <= push_data;
      end

      assign full    = vld;
      assign empty   = !vld;
      assign rd_data = hold;
   end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      localparam int CW = $clog2(DEPTH + 1);
      localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
      localparam logic [CW-1:0] CAP  = CW'(DEPTH);

      logic [CHAR_W-1:0] mem [DEPTH];
      logic [PW-1:0]     wp, rp;
      logic [CW-1:0]     cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
         end else if (flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
         end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            unique case ({do_push, do_pop})
               2'b10:   cnt <= cnt + 1'b1;
               2'b01:   cnt <= cnt - 1'b1;
               default: cnt <= cnt;
            endcase
         end
      end

      always_ff @(posedge clk) begin
         if (do_push) mem[wp] <= push_data;
      end

      assign full    = (cnt == CAP);
      assign empty   = (cnt == '0);
      assign rd_data = mem[rp];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               ovf <= 1'b0;
      else if (flush)                           ovf <= 1'b0;
      else if (push_req && full && !do_pop)     ovf <= 1'b1;
   end

   assign rd_valid = !empty;

   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) flush |=> (!rd_valid && !ovf)); // R3
   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n) (push_req && full && !pop && !flush) |=> (ovf && full)); // R10
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!push_req && !pop && !flush) |=> ($stable(full) && $stable(empty) && $stable(ovf))); // R8

endmodule

// File: rtl/spi_rxen_ctrl.sv
module spi_rxen_ctrl #(
   parameter int CHAR_W      = 9,
   parameter int DEPTH       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_val,
   input  logic              periph_en,
   input  logic              rx_rdy,
   input  logic              char_done,
   input  logic [CHAR_W-1:0] char_data,
   input  logic              pop,
   output logic              rx_en_req,
   output logic              rxen_rd,
   output logic              sync_busy,
   output logic              flush,
   output logic              ovf_clr,
   output logic              rd_valid,
   output logic [CHAR_W-1:0] rd_data,
   output logic              ovf
);

   logic rdy_s;
   logic accept;

   spi_rxen_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_rdy),
      .q     (rdy_s)
   );

   spi_rxen_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_val    (wr_val),
      .periph_en (periph_en),
      .rdy_s     (rdy_s),
      .req       (rx_en_req),
      .rd        (rxen_rd),
      .busy      (sync_busy),
      .flush     (flush)
   );

   // Characters count only while the receiver is settled on and the peripheral runs
   assign accept = char_done && rxen_rd && periph_en;

   spi_rxen_fifo #(.CHAR_W(CHAR_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .push_req  (accept),
      .push_data (char_data),
      .pop       (pop),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .ovf       (ovf)
   );

   assign ovf_clr = flush && ovf;

   AST_OVF_CLR_DROP: assert property (@(posedge clk) disable iff (!rst_n) ovf_clr |=> !ovf); // R11
   AST_OFF_IGNORE: assert property (@(posedge clk) disable iff (!rst_n) (char_done && !rxen_rd && !pop && !flush) |=> ($stable(rd_valid) && $stable(ovf))); // R8

endmodule

// File: tb/tb_spi_rxen_ctrl.sv
module tb_spi_rxen_ctrl;

   localparam int CW  = 9;
   localparam int DEP = 4;

   logic clk = 1'b0;
   logic rx_clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, wr_val = 1'b0, periph_en = 1'b0, rx_rdy;
   logic char_done = 1'b0, pop = 1'b0;
   logic [CW-1:0] char_data = '0;
   logic rx_en_req, rxen_rd, sync_busy, flush, ovf_clr, rd_valid, ovf;
   logic [CW-1:0] rd_data;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;       // 250 MHz
   always #6 rx_clk = ~rx_clk; // slower receive domain

   // Receive-path model: confirms the request after two of its own clocks
   logic rq1 = 1'b0, rq2 = 1'b0;
   always @(posedge rx_clk) begin
      rq1 <= rx_en_req;
      rq2 <= rq1;
   end
   assign rx_rdy = rq2;

   spi_rxen_ctrl #(.CHAR_W(CW), .DEPTH(DEP), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_val(wr_val),
      .periph_en(periph_en), .rx_rdy(rx_rdy), .char_done(char_done),
      .char_data(char_data), .pop(pop), .rx_en_req(rx_en_req),
      .rxen_rd(rxen_rd), .sync_busy(sync_busy), .flush(flush),
      .ovf_clr(ovf_clr), .rd_valid(rd_valid), .rd_data(rd_data), .ovf(ovf)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic v);
      wr_en = 1'b1; wr_val = v;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic push(input logic [CW-1:0] d);
      char_done = 1'b1; char_data = d;
      tick();
      char_done = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      int n = 0;
      while (sync_busy && n < 20) begin tick(); n++; end
      chk(!sync_busy, req, "busy cleared within bound", int'(sync_busy), 0);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++; checks++;
      $display("FAIL R6 watchdog actual=running expected=done");
      finish_run();
   end

   function automatic bit model_full(input int sz);
      return sz == DEP;
   endfunction

   initial begin
      logic [CW-1:0] mq[$];
      bit movf;
      logic [CW-1:0] exp_d [4];
      void'($urandom(32'h0051_7E55));
      exp_d[0] = 9'h101; exp_d[1] = 9'h0A5; exp_d[2] = 9'h1FF; exp_d[3] = 9'h042;

      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk(!rx_en_req && !rxen_rd && !sync_busy && !flush && !ovf_clr, "R1", "control outputs low", int'(rxen_rd|sync_busy|flush), 0);
      chk(!rd_valid && !ovf, "R1", "fifo empty, no overflow", int'(rd_valid|ovf), 0);

      // R4 enable while peripheral idle
      wr(1'b1);
      chk(rxen_rd && !sync_busy, "R4", "immediate enable", int'(rxen_rd), 1);
      repeat (20) tick();
      periph_en = 1'b1;
      // R12 repeated write of 1
      wr(1'b1);
      chk(rxen_rd && !sync_busy, "R12", "rewrite one no effect", int'(sync_busy), 0);

      // R9 order, R10 overflow
      for (int i = 0; i < 4; i++) push(exp_d[i]);
      chk(rd_valid && rd_data == exp_d[0], "R9", "head after fill", int'(rd_data), int'(exp_d[0]));
      push(9'h0EE);
      chk(ovf == 1'b1, "R10", "overflow on full", int'(ovf), 1);
      for (int i = 0; i < 4; i++) begin
         chk(rd_valid && rd_data == exp_d[i], "R9", "pop order", int'(rd_data), int'(exp_d[i]));
         pop = 1'b1; tick(); pop = 1'b0;
      end
      chk(!rd_valid, "R10", "dropped char absent", int'(rd_valid), 0);
      pop = 1'b1; tick(); pop = 1'b0;
      chk(!rd_valid && ovf, "R9", "pop on empty no effect", int'(rd_valid), 0);

      // R2 / R11 disable with overflow set, R3 after flush
      wr_en = 1'b1; wr_val = 1'b0;
      tick();
      wr_en = 1'b0;
      chk(!rxen_rd && !rx_en_req && flush, "R2", "disable and flush", int'(flush), 1);
      chk(ovf_clr, "R11", "ovf_clr with overflow set", int'(ovf_clr), 1);
      tick();
      chk(!flush, "R2", "flush one cycle", int'(flush), 0);
      chk(!ovf && !rd_valid, "R3", "cleared after flush", int'(ovf), 0);

      // R8 ignored while disabled
      push(9'h033);
      chk(!rd_valid && !ovf, "R8", "char ignored when off", int'(rd_valid), 0);
      repeat (20) tick();

      // R5 deferred enable, R8 ignored while pending, R6 completion
      wr(1'b1);
      chk(sync_busy && !rxen_rd && rx_en_req, "R5", "deferred enable", int'(sync_busy), 1);
      push(9'h044);
      chk(!rd_valid, "R8", "char ignored while pending", int'(rd_valid), 0);
      wait_idle("R6");
      chk(rxen_rd, "R6", "reads one after confirm", int'(rxen_rd), 1);

      // R11 disable without overflow
      wr(1'b0);
      chk(flush && !ovf_clr, "R11", "no ovf_clr when clear", int'(ovf_clr), 0);
      repeat (20) tick();

      // R7 cancel a pending enable
      wr(1'b1);
      tick();
      wr(1'b0);
      chk(!rxen_rd && !rx_en_req, "R7", "cancel reads zero", int'(rxen_rd), 0);
      wait_idle("R7");
      chk(!rxen_rd, "R7", "stays off after cancel", int'(rxen_rd), 0);
      repeat (20) tick();

      // Random traffic with the receiver enabled
      wr(1'b1);
      wait_idle("R6");
      movf = 1'b0;
      for (int c = 0; c < 400; c++) begin
         bit cd, pp, dp;
         int sz;
         cd = ($urandom % 100) < 50;
         pp = ($urandom % 100) < 35;
         char_done = cd; pop = pp; char_data = CW'($urandom);
         tick();
         sz = mq.size();
         dp = pp && sz > 0;
         if (dp) void'(mq.pop_front());
         if (cd) begin
            if (!model_full(sz) || dp) mq.push_back(char_data);
            else movf = 1'b1;
         end
         chk(rd_valid == (mq.size() > 0), "R9", "random rd_valid", int'(rd_valid), int'(mq.size() > 0));
         chk(ovf == movf, "R10", "random ovf", int'(ovf), int'(movf));
         if (mq.size() > 0)
            chk(rd_data == mq[0], "R9", "random head", int'(rd_data), int'(mq[0]));
      end
      char_done = 1'b0; pop = 1'b0;

      // R3 flush with data present and a char completing in the write cycle
      push(9'h111);
      wr_en = 1'b1; wr_val = 1'b0; char_done = 1'b1; char_data = 9'h122;
      tick();
      wr_en = 1'b0;
      tick();
      char_done = 1'b0;
      chk(!rd_valid && !ovf, "R3", "flush discards pending chars", int'(rd_valid), 0);

      finish_run();
   end

endmodule